// File: doc/BRIEF.md
# Four-Channel Block Playback Scheduler

This block keeps the playback queue for four audio channels. Each channel holds at most two block handles: a current slot that is being played and a next slot that waits behind it. A downstream drain engine reads a ping-pong output buffer. Each time it finishes reading one half, it raises a half-done event. The scheduler answers that event with a fill descriptor. The descriptor names the buffer half to refill and gives, for every channel, either the handle and sample offset of the half block to copy or a silence marker. Block memory is outside the block; only handles pass through it.

Producers hand over blocks one at a time on a push port, tagged with a channel index. A block that finishes playing, or that is pushed out by overflow, goes back to the allocator on a per-channel release port. Each block covers two consecutive half-buffer events: first from offset 0, then from offset BLOCK_SAMPLES/2. An event that arrives while the drain reads the first half also raises a request for the rest of the system to produce new blocks.

Top module: `quad_block_sched`

## Requirements
- R1: After synchronous reset, `fill_valid`, `update_req` and every `rel_valid` bit are 0, and every channel starts empty.
- R2: An event on `evt_valid` produces a `fill_valid` pulse one cycle later. `fill_half` is the inverse of the sampled `evt_half`: 1 means refill the second half, 0 the first.
- R3: `update_req` pulses together with the fill only when the event had `evt_half` = 0 (first half being read). It stays low for events with `evt_half` = 1.
- R4: A channel with no current block reports `src_valid` = 0 (silence) with offset 0, and the event does not advance its state.
- R5: A block pushed into a channel with an empty current slot becomes current with offset 0.
- R6: A current block is reported at offset 0 on its first event and at offset BLOCK_SAMPLES/2 on its second.
- R7: On the event that reports offset BLOCK_SAMPLES/2, the current handle is released. The next block becomes current at offset 0, and the next slot becomes empty.
- R8: A block pushed while only the next slot is free goes into the next slot, and nothing is released.
- R9: A block pushed while both slots are full releases the current handle. The old next block becomes current with offset reset to 0, and the new block becomes next.
- R10: When a push and an event reach the same channel in one cycle, the event is applied first and the push second.
- R11: Each release is a one-cycle pulse on that channel's `rel_valid` bit, carrying the handle on its `rel_handle` field. It appears the cycle after the push or event that caused it, and at most one release per channel per cycle occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Half-done event from the drain engine |
| evt_half | input | 1 | Half currently being read: 0 first, 1 second |
| push_valid | input | 1 | A new block is offered |
| push_ch | input | 2 | Target channel of the push |
| push_handle | input | 8 | Handle of the pushed block |
| fill_valid | output | 1 | Fill descriptor is new this cycle |
| fill_half | output | 1 | Half to refill: 0 first, 1 second |
| update_req | output | 1 | Request for the system to produce new blocks |
| src_valid | output | 4 | Per channel: 1 copy from handle, 0 copy silence |
| src_handle | output | 32 | Per channel source handle, channel c at bits [8c+7:8c] |
| src_offset | output | 28 | Per channel sample offset, channel c at bits [7c+6:7c] |
| rel_valid | output | 4 | Per channel release pulse |
| rel_handle | output | 32 | Per channel released handle, channel c at bits [8c+7:8c] |

## Verification
A push and a half-done event can land on the same channel in the same cycle. The event can wrap the offset and release the current block while the push needs a free slot. The bench drives both in one cycle to a channel whose current block sits at its second half and whose next slot is full. Event-first order reports the old block at offset 64, releases it, and queues the new block behind the promoted one. The reverse order would report the promoted block at offset 0, so the descriptor and the later sequence of handles tell the two orders apart. A second case sends both to an empty channel: the fill must show silence, and the pushed block must appear at offset 0 on the following event.

// File: rtl/qbs_pkg.sv
// Package: shared defaults and the push-placement encoding used by the
// per-channel slot logic. Assumes nothing about the surrounding system.
package qbs_pkg;
    localparam int DEF_NCH           = 4;
    localparam int DEF_HW            = 8;
    localparam int DEF_BLOCK_SAMPLES = 128;

    // Where an incoming block is placed, decided after any event step.
    typedef enum logic [1:0] {
        PLACE_NONE  = 2'd0,
        PLACE_CUR   = 2'd1,
        PLACE_NXT   = 2'd2,
        PLACE_EVICT = 2'd3
    } place_e;
endpackage

// File: rtl/qbs_fill.sv
// Module: qbs_fill
// Turns a half-done event into the registered fill strobe, the half to
// refill and the update request. Assumes evt_half names the half that
// the drain engine is reading when the event is raised.
module qbs_fill (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_valid,
    input  logic evt_half,
    output logic fill_valid,
    output logic fill_half,
    output logic update_req
);
    // Register the fill strobe, target half and update request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_valid <= 1'b0;
            fill_half  <= 1'b0;
            update_req <= 1'b0;
        end else begin
            fill_valid <= evt_valid;
            update_req <= evt_valid && !evt_half;
            if (evt_valid) begin
                fill_half <= ~evt_half;
            end
        end
    end
endmodule

// File: rtl/qbs_chan.sv
// Module: qbs_chan
// Two-slot queue for one channel. A block is played in two halves; the
// event step runs before the push step within a cycle. Reports the pre-event
// slot contents as the fill source and releases at most one handle per
// cycle. Assumes push is asserted only for this channel.
module qbs_chan
    import qbs_pkg::*;
#(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          push,
    input  logic [HW-1:0] push_handle,
    output logic          src_valid,
    output logic [HW-1:0] src_handle,
    output logic          src_second,
    output logic          rel_valid,
    output logic [HW-1:0] rel_handle
);
    logic          cur_v, nxt_v, off_q;
    logic [HW-1:0] cur_q, nxt_q;

    logic          a_cur_v, a_nxt_v, a_off;
    logic [HW-1:0] a_cur;
    logic          b_cur_v, b_nxt_v, b_off;
    logic [HW-1:0] b_cur, b_nxt;
    logic          rel_d;
    logic [HW-1:0] relh_d;
    place_e        place;

    // Event step: advance the offset or retire the current block.
    always_comb begin
        a_cur_v = cur_v;
        a_nxt_v = nxt_v;
        a_off   = off_q;
        a_cur   = cur_q;
        rel_d   = 1'b0;
        relh_d  = cur_q;
        if (evt && cur_v) begin
            if (!off_q) begin
                a_off = 1'b1;
            end else begin
                rel_d   = 1'b1;
                relh_d  = cur_q;
                a_cur   = nxt_q;
                a_cur_v = nxt_v;
                a_nxt_v = 1'b0;
                a_off   = 1'b0;
            end
        end
    end

    // Choose where a pushed block lands, given the post-event slots.
    always_comb begin
        if (!push)        place = PLACE_NONE;
        else if (!a_cur_v) place = PLACE_CUR;
        else if (!a_nxt_v) place = PLACE_NXT;
        else               place = PLACE_EVICT;
    end

    // Push step: apply the placement on top of the event step.
    always_comb begin
        b_cur_v = a_cur_v;
        b_nxt_v = a_nxt_v;
        b_off   = a_off;
        b_cur   = a_cur;
        b_nxt   = nxt_q;
        unique case (place)
            PLACE_CUR: begin
                b_cur   = push_handle;
                b_cur_v = 1'b1;
                b_off   = 1'b0;
            end
            PLACE_NXT: begin
                b_nxt   = push_handle;
                b_nxt_v = 1'b1;
            end
            PLACE_EVICT: begin
                b_cur = nxt_q;
                b_nxt = push_handle;
                b_off = 1'b0;
            end
            default: ;
        endcase
    end

    // Release request from either step; the two never coincide.
    logic          rel_any;
    logic [HW-1:0] rel_any_h;
    always_comb begin
        rel_any   = rel_d || (place == PLACE_EVICT);
        rel_any_h = (place == PLACE_EVICT) ? a_cur : relh_d;
    end

    // Slot state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_v <= 1'b0;
            nxt_v <= 1'b0;
            off_q <= 1'b0;
            cur_q <= '0;
            nxt_q <= '0;
        end else begin
            cur_v <= b_cur_v;
            nxt_v <= b_nxt_v;
            off_q <= b_off;
            cur_q <= b_cur;
            nxt_q <= b_nxt;
        end
    end

    // Capture the fill source on an event and hold it until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_valid  <= 1'b0;
            src_handle <= '0;
            src_second <= 1'b0;
        end else if (evt) begin
            src_valid  <= cur_v;
            src_handle <= cur_v ? cur_q : '0;
            src_second <= cur_v && off_q;
        end
    end

    // One-cycle release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_valid  <= 1'b0;
            rel_handle <= '0;
        end else begin
            rel_valid  <= rel_any;
            rel_handle <= rel_any ? rel_any_h : '0;
        end
    end
endmodule

// File: rtl/quad_block_sched.sv
// Module: quad_block_sched
// Top of the playback scheduler: one event decoder plus NCH channel queues.
// Assumes one push per cycle and that the fill descriptor is consumed
// before the next event replaces it.
module quad_block_sched
    import qbs_pkg::*;
#(
    parameter int NCH           = DEF_NCH,
    parameter int HW            = DEF_HW,
    parameter int BLOCK_SAMPLES = DEF_BLOCK_SAMPLES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     evt_valid,
    input  logic                     evt_half,
    input  logic                     push_valid,
    input  logic [$clog2(NCH)-1:0]   push_ch,
    input  logic [HW-1:0]            push_handle,
    output logic                     fill_valid,
    output logic                     fill_half,
    output logic                     update_req,
    output logic [NCH-1:0]           src_valid,
    output logic [NCH*HW-1:0]        src_handle,
    output logic [NCH*$clog2(BLOCK_SAMPLES)-1:0] src_offset,
    output logic [NCH-1:0]           rel_valid,
    output logic [NCH*HW-1:0]        rel_handle
);
    localparam int CHW  = $clog2(NCH);
    localparam int OFFW = $clog2(BLOCK_SAMPLES);
    localparam logic [OFFW-1:0] HALF_OFF = OFFW'(BLOCK_SAMPLES / 2);

    qbs_fill u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_half   (evt_half),
        .fill_valid (fill_valid),
        .fill_half  (fill_half),
        .update_req (update_req)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel, second;
        // Steer the single push port to this channel.
        always_comb sel = push_valid && (push_ch == CHW'(c));

        qbs_chan #(.HW(HW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .evt         (evt_valid),
            .push        (sel),
            .push_handle (push_handle),
            .src_valid   (src_valid[c]),
            .src_handle  (src_handle[c*HW +: HW]),
            .src_second  (second),
            .rel_valid   (rel_valid[c]),
            .rel_handle  (rel_handle[c*HW +: HW])
        );

        // Expand the half flag into a sample offset.
        always_comb src_offset[c*OFFW +: OFFW] = second ? HALF_OFF : '0;
    end
endmodule

// File: rtl/qbs_checker.sv
// Module: qbs_checker
// Port-level properties of the scheduler, bound to every instance.
module qbs_checker #(
    parameter int NCH           = 4,
    parameter int HW            = 8,
    parameter int BLOCK_SAMPLES = 128
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     evt_valid,
    input logic                     evt_half,
    input logic                     push_valid,
    input logic [$clog2(NCH)-1:0]   push_ch,
    input logic [HW-1:0]            push_handle,
    input logic                     fill_valid,
    input logic                     fill_half,
    input logic                     update_req,
    input logic [NCH-1:0]           src_valid,
    input logic [NCH*HW-1:0]        src_handle,
    input logic [NCH*$clog2(BLOCK_SAMPLES)-1:0] src_offset,
    input logic [NCH-1:0]           rel_valid,
    input logic [NCH*HW-1:0]        rel_handle
);
    localparam int CHW  = $clog2(NCH);
    localparam int OFFW = $clog2(BLOCK_SAMPLES);
    localparam logic [OFFW-1:0] HALF_OFF = OFFW'(BLOCK_SAMPLES / 2);

    AST_FILL_AFTER_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> fill_valid);                                   // R2
    AST_NO_FILL_WITHOUT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> !fill_valid);                                 // R2
    AST_FILL_HALF_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> (fill_half == !$past(evt_half)));              // R2
    AST_UPDATE_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        update_req |-> (fill_valid && fill_half));                   // R3

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_SILENT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_valid && !src_valid[c]) |-> (src_offset[c*OFFW +: OFFW] == '0)); // R4
        AST_OFFSET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            (src_offset[c*OFFW +: OFFW] == '0) ||
            (src_offset[c*OFFW +: OFFW] == HALF_OFF));                // R6
        AST_REL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            rel_valid[c] |-> $past(evt_valid ||
                                   (push_valid && push_ch == CHW'(c)))); // R11
        AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_valid |=> $stable(src_handle[c*HW +: HW]));         // R2
    end
endmodule

bind quad_block_sched qbs_checker #(
    .NCH(NCH), .HW(HW), .BLOCK_SAMPLES(BLOCK_SAMPLES)
) u_qbs_checker (.*);

// File: tb/tb_quad_block_sched.sv
module tb_quad_block_sched;
    localparam int NCH = 4, HW = 8, BS = 128, OFFW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 1'b0, evt_half = 1'b0;
    logic push_valid = 1'b0;
    logic [1:0] push_ch = '0;
    logic [HW-1:0] push_handle = '0;
    logic fill_valid, fill_half, update_req;
    logic [NCH-1:0] src_valid, rel_valid;
    logic [NCH*HW-1:0] src_handle, rel_handle;
    logic [NCH*OFFW-1:0] src_offset;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    quad_block_sched #(.NCH(NCH), .HW(HW), .BLOCK_SAMPLES(BS)) dut (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_half(evt_half),
        .push_valid(push_valid), .push_ch(push_ch), .push_handle(push_handle),
        .fill_valid(fill_valid), .fill_half(fill_half), .update_req(update_req),
        .src_valid(src_valid), .src_handle(src_handle), .src_offset(src_offset),
        .rel_valid(rel_valid), .rel_handle(rel_handle)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs from a falling edge, sample at the next falling edge.
    task automatic cyc(input logic ev, input logic half, input logic pv,
                       input int ch, input int h);
        evt_valid   = ev;
        evt_half    = half;
        push_valid  = pv;
        push_ch     = 2'(ch);
        push_handle = HW'(h);
        @(posedge clk);
        @(negedge clk);
        evt_valid  = 1'b0;
        push_valid = 1'b0;
    endtask

    function automatic int s_h(input int c);  return int'(src_handle[c*HW +: HW]); endfunction
    function automatic int s_o(input int c);  return int'(src_offset[c*OFFW +: OFFW]); endfunction
    function automatic int r_h(input int c);  return int'(rel_handle[c*HW +: HW]); endfunction

    // Expect a fill descriptor for channel c.
    task automatic exp_src(input string req, input int c, input int v, input int h, input int o);
        check(req, "fill_valid", int'(fill_valid), 1);
        check(req, "src_valid", int'(src_valid[c]), v);
        if (v != 0) check(req, "src_handle", s_h(c), h);
        check(req, "src_offset", s_o(c), o);
    endtask

    task automatic exp_rel(input string req, input int c, input int v, input int h);
        check(req, "rel_valid", int'(rel_valid[c]), v);
        if (v != 0) check(req, "rel_handle", r_h(c), h);
    endtask

    task automatic t_reset;
        check("R1", "fill_valid after reset", int'(fill_valid), 0);
        check("R1", "update_req after reset", int'(update_req), 0);
        check("R1", "rel_valid after reset", int'(rel_valid), 0);
        cyc(1, 0, 0, 0, 0);
        check("R2", "fill_half for evt_half=0", int'(fill_half), 1);
        check("R3", "update_req for evt_half=0", int'(update_req), 1);
        check("R1", "all channels silent", int'(src_valid), 0);
        cyc(0, 0, 0, 0, 0);
        check("R2", "fill_valid drops", int'(fill_valid), 0);
        check("R3", "update_req drops", int'(update_req), 0);
        cyc(1, 1, 0, 0, 0);
        check("R2", "fill_half for evt_half=1", int'(fill_half), 0);
        check("R3", "no update_req for evt_half=1", int'(update_req), 0);
    endtask

    task automatic t_empty;
        cyc(1, 0, 0, 0, 0);
        exp_src("R4", 2, 0, 0, 0);
        cyc(1, 1, 0, 0, 0);
        exp_src("R4", 2, 0, 0, 0);
        exp_rel("R4", 2, 0, 0);
    endtask

    task automatic t_basic;
        cyc(0, 0, 1, 1, 8'h11);
        exp_rel("R5", 1, 0, 0);
        cyc(0, 0, 1, 1, 8'h22);
        exp_rel("R8", 1, 0, 0);
        cyc(1, 0, 0, 0, 0);
        exp_src("R5", 1, 1, 8'h11, 0);
        exp_rel("R6", 1, 0, 0);
        cyc(1, 1, 0, 0, 0);
        exp_src("R6", 1, 1, 8'h11, 64);
        exp_rel("R7", 1, 1, 8'h11);
        cyc(0, 0, 0, 0, 0);
        exp_rel("R11", 1, 0, 0);
        cyc(1, 0, 0, 0, 0);
        exp_src("R7", 1, 1, 8'h22, 0);
        cyc(1, 1, 0, 0, 0);
        exp_src("R7", 1, 1, 8'h22, 64);
        exp_rel("R7", 1, 1, 8'h22);
        cyc(1, 0, 0, 0, 0);
        exp_src("R7", 1, 0, 0, 0);
        exp_rel("R11", 1, 0, 0);
    endtask

    task automatic t_overwrite;
        cyc(0, 0, 1, 2, 8'h31);
        cyc(1, 1, 0, 0, 0);
        exp_src("R5", 2, 1, 8'h31, 0);
        cyc(0, 0, 1, 2, 8'h32);
        exp_rel("R8", 2, 0, 0);
        cyc(0, 0, 1, 2, 8'h33);
        exp_rel("R9", 2, 1, 8'h31);
        cyc(0, 0, 0, 0, 0);
        exp_rel("R11", 2, 0, 0);
        cyc(1, 0, 0, 0, 0);
        exp_src("R9", 2, 1, 8'h32, 0);
        cyc(1, 1, 0, 0, 0);
        exp_src("R9", 2, 1, 8'h32, 64);
        exp_rel("R9", 2, 1, 8'h32);
        cyc(1, 0, 0, 0, 0);
        exp_src("R9", 2, 1, 8'h33, 0);
        cyc(1, 1, 0, 0, 0);
        exp_rel("R9", 2, 1, 8'h33);
    endtask

    task automatic t_same_cycle;
        cyc(0, 0, 1, 3, 8'h41);
        cyc(1, 0, 0, 0, 0);
        exp_src("R10", 3, 1, 8'h41, 0);
        cyc(0, 0, 1, 3, 8'h42);
        cyc(1, 1, 1, 3, 8'h43);
        exp_src("R10", 3, 1, 8'h41, 64);
        exp_rel("R10", 3, 1, 8'h41);
        cyc(1, 0, 0, 0, 0);
        exp_src("R10", 3, 1, 8'h42, 0);
        cyc(1, 1, 0, 0, 0);
        exp_rel("R10", 3, 1, 8'h42);
        cyc(1, 0, 0, 0, 0);
        exp_src("R10", 3, 1, 8'h43, 0);
        // Empty channel 0: event and push together.
        cyc(1, 1, 1, 0, 8'h51);
        exp_src("R10", 0, 0, 0, 0);
        exp_rel("R10", 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        exp_src("R10", 0, 1, 8'h51, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_basic();
        t_overwrite();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule